// File: doc/BRIEF.md
# Burst Memory Cycle Engine

This block runs memory cycles on an 8-bit microprocessor bus that some other logic has already taken over. A single command starts one of four operations: one byte read, one byte write, a fill that writes one value over a run of consecutive addresses, or a block copy that writes a stream of bytes to consecutive addresses. The block drives a 19-bit address, the write data and its output enable, and three active-low strobes: memory request, read and write. It returns the read byte together with a one-cycle done pulse.

Single cycles open and close the memory request around one strobe pulse. In fill and block copy, memory request stays low for the whole burst. Each byte gets its own write-strobe pulse, and the address steps up by one between pulses. Block-copy bytes come in over a valid/ready stream, and the burst waits for the source whenever it stalls. The read and write strobe widths are parameters given in clock cycles.

Top module: `memcyc_engine`

## Requirements
- R1: After reset, mreq_n, rd_n and wr_n are high, and bus_oe, busy, done and s_ready are low.
- R2: A write (cmd 1) gives exactly one wr_n low pulse of WR_W cycles. During the pulse, bus_oe is high and bus_addr and bus_dout hold the command's addr and wdata.
- R3: A strobe is low only while mreq_n is low, and rd_n and wr_n are never low together. mreq_n falls before the first strobe falls and rises only after the last strobe has risen.
- R4: A read (cmd 0) gives exactly one rd_n low pulse of RD_W cycles. rdata then holds the byte present on bus_din in the last low cycle.
- R5: bus_oe is never high while rd_n is low, nor at any time during a read command.
- R6: A fill (cmd 2) of length L>0 gives L wr_n pulses that write wdata to addr, addr+1 and so on, with one mreq_n low period for the whole burst.
- R7: A block copy (cmd 3) of length L>0 writes the L bytes taken on s_valid&s_ready to consecutive addresses from addr, in arrival order. s_ready is high only while a block copy waits for its next byte.
- R8: A fill or block copy with len 0 raises done one cycle after start is taken. It produces no strobe and no mreq_n activity.
- R9: The burst address counts across all 19 bits. Bits 18:16 form the bank, and the address wraps from 0x7FFFF to 0x00000.
- R10: start is ignored while busy is high.
- R11: done is a one-cycle pulse. busy stays high from the cycle after start until the done cycle. A write takes WR_W+3 cycles, a read RD_W+3 cycles and a fill of length L takes L*(WR_W+1)+2 cycles, each counted from start being taken to done. len is ignored for read and write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a command (taken when idle) |
| cmd | input | 2 | 0 read, 1 write, 2 fill, 3 block copy |
| addr | input | 19 | Start address (bank in bits 18:16) |
| wdata | input | 8 | Write or fill byte |
| len | input | LEN_W | Burst length for fill and block copy |
| s_valid | input | 1 | Block-copy byte valid |
| s_data | input | 8 | Block-copy byte |
| s_ready | output | 1 | Engine accepts a block-copy byte |
| bus_addr | output | 19 | Bus address |
| bus_dout | output | 8 | Bus write data |
| bus_din | input | 8 | Bus read data |
| bus_oe | output | 1 | Write data output enable |
| mreq_n | output | 1 | Memory request, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte from the last read |

## Verification
The assertions assume the bus has already been handed over and that bus_din is settled during a read strobe. They also assume start is only meaningful while busy is low. The stimulus provides a bus-side memory model that answers on bus_din while rd_n is low. It issues random commands with short lengths and addresses biased toward the bank and top-of-space boundaries. It also pulses start in the middle of a burst and stalls the block-copy stream at random, so that the ignore rules and the stall path are both exercised.

// File: rtl/memcyc_pkg.sv
package memcyc_pkg;

    localparam int BANK_W = 3;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = BANK_W + 2 * BYTE_W;

    typedef enum logic [1:0] {
        CMD_READ  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_FILL  = 2'd2,
        CMD_BLOCK = 2'd3
    } mc_cmd_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } mc_addr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_ADDR,
        ST_STROBE,
        ST_HOLD,
        ST_FIN
    } mc_state_e;

    function automatic logic is_burst(mc_cmd_e c);
        return (c == CMD_FILL) || (c == CMD_BLOCK);
    endfunction

    function automatic logic is_write_kind(mc_cmd_e c);
        return c != CMD_READ;
    endfunction

    function automatic mc_addr_t addr_next(mc_addr_t a);
        logic [ADDR_W-1:0] flat;
        flat = a;
        flat = flat + 1'b1;
        return flat;
    endfunction

endpackage

// File: rtl/memcyc_strobe_timer.sv
module memcyc_strobe_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/memcyc_burst_tracker.sv
module memcyc_burst_tracker
    import memcyc_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  mc_addr_t         load_addr,
    input  logic [LEN_W-1:0] load_len,
    output mc_addr_t         cur_addr,
    output logic             last
);
    mc_addr_t         addr_q;
    logic [LEN_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            remain_q <= '0;
        end else if (load) begin
            addr_q   <= load_addr;
            remain_q <= load_len;
        end else if (step) begin
            addr_q   <= addr_next(addr_q);
            remain_q <= remain_q - 1'b1;
        end
    end

    assign cur_addr = addr_q;
    assign last     = (remain_q == LEN_W'(1));
endmodule

// File: rtl/memcyc_engine.sv
module memcyc_engine
    import memcyc_pkg::*;
#(
    parameter int WR_W  = 2,
    parameter int RD_W  = 3,
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [LEN_W-1:0]  len,
    input  logic              s_valid,
    input  logic [BYTE_W-1:0] s_data,
    output logic              s_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BYTE_W-1:0] bus_dout,
    input  logic [BYTE_W-1:0] bus_din,
    output logic              bus_oe,
    output logic              mreq_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rdata
);
    localparam int MAX_W = (WR_W > RD_W) ? WR_W : RD_W;
    localparam int CNT_W = $clog2(MAX_W + 1);

    mc_state_e         state_q, state_d;
    mc_cmd_e           cmd_q;
    mc_cmd_e           cmd_in;
    logic [BYTE_W-1:0] data_q, rdata_q;
    logic              accept, zero_len, t_last, trk_last, step, strobe_end;
    logic              bus_held;
    mc_addr_t          trk_addr;
    logic [LEN_W-1:0]  first_len;
    logic [CNT_W-1:0]  width_sel;

    assign cmd_in     = mc_cmd_e'(cmd);
    assign accept     = (state_q == ST_IDLE) && start;
    assign zero_len   = is_burst(cmd_in) && (len == '0);
    assign first_len  = is_burst(cmd_in) ? len : LEN_W'(1);
    assign width_sel  = (cmd_q == CMD_READ) ? CNT_W'(RD_W) : CNT_W'(WR_W);
    assign strobe_end = (state_q == ST_STROBE) && t_last;
    assign step       = strobe_end && !trk_last;

    memcyc_burst_tracker #(.LEN_W(LEN_W)) u_track (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .step      (step),
        .load_addr (addr),
        .load_len  (first_len),
        .cur_addr  (trk_addr),
        .last      (trk_last)
    );

    memcyc_strobe_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (state_q == ST_ADDR),
        .load_val (width_sel),
        .last     (t_last)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (zero_len)                  state_d = ST_FIN;
                    else if (cmd_in == CMD_BLOCK)  state_d = ST_FETCH;
                    else                           state_d = ST_ADDR;
                end
            end
            ST_FETCH:  if (s_valid) state_d = ST_ADDR;
            ST_ADDR:   state_d = ST_STROBE;
            ST_STROBE: begin
                if (t_last) begin
                    if (trk_last)                  state_d = ST_HOLD;
                    else if (cmd_q == CMD_BLOCK)   state_d = ST_FETCH;
                    else                           state_d = ST_ADDR;
                end
            end
            ST_HOLD:   state_d = ST_FIN;
            ST_FIN:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cmd_q   <= CMD_READ;
            data_q  <= '0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cmd_q  <= cmd_in;
                data_q <= wdata;
            end
            if ((state_q == ST_FETCH) && s_valid) begin
                data_q <= s_data;
            end
            if (strobe_end && (cmd_q == CMD_READ)) begin
                rdata_q <= bus_din;
            end
        end
    end

    assign bus_held = (state_q == ST_FETCH) || (state_q == ST_ADDR) ||
                      (state_q == ST_STROBE) || (state_q == ST_HOLD);

    assign mreq_n   = !bus_held;
    assign rd_n     = !((state_q == ST_STROBE) && (cmd_q == CMD_READ));
    assign wr_n     = !((state_q == ST_STROBE) && is_write_kind(cmd_q));
    assign bus_oe   = bus_held && is_write_kind(cmd_q);
    assign bus_addr = trk_addr;
    assign bus_dout = data_q;
    assign s_ready  = (state_q == ST_FETCH);
    assign busy     = (state_q != ST_IDLE);
    assign done     = (state_q == ST_FIN);
    assign rdata    = rdata_q;
endmodule

// File: rtl/memcyc_engine_chk.sv
module memcyc_engine_chk #(
    parameter int WR_W = 2,
    parameter int RD_W = 3
) (
    input logic        clk,
    input logic        rst,
    input logic        mreq_n,
    input logic        rd_n,
    input logic        wr_n,
    input logic        bus_oe,
    input logic [18:0] bus_addr,
    input logic        busy,
    input logic        done,
    input logic        s_ready
);
    logic [15:0] wr_run, rd_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_run <= '0;
            rd_run <= '0;
        end else begin
            wr_run <= !wr_n ? wr_run + 1'b1 : '0;
            rd_run <= !rd_n ? rd_run + 1'b1 : '0;
        end
    end

    AST_WR_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_n) |-> (wr_run == 16'(WR_W))); // R2
    AST_WR_DRIVES: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> bus_oe); // R2
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && $past(!wr_n)) |-> $stable(bus_addr)); // R2
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n)); // R3
    AST_STROBE_IN_MREQ: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> !mreq_n); // R3
    AST_MREQ_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(mreq_n) |-> ($past(rd_n) && $past(wr_n))); // R3
    AST_RD_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_n) |-> (rd_run == 16'(RD_W))); // R4
    AST_NO_OE_READ: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !bus_oe); // R5
    AST_READY_BUSY: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> (busy && mreq_n == 1'b0)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11
endmodule

bind memcyc_engine memcyc_engine_chk #(.WR_W(WR_W), .RD_W(RD_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mreq_n   (mreq_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .bus_oe   (bus_oe),
    .bus_addr (bus_addr),
    .busy     (busy),
    .done     (done),
    .s_ready  (s_ready)
);

// File: tb/memcyc_engine_test.sv
module memcyc_engine_test;
    localparam int WR_W  = 2;
    localparam int RD_W  = 3;
    localparam int LEN_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [1:0]        cmd = 2'd0;
    logic [18:0]       addr = '0;
    logic [7:0]        wdata = '0;
    logic [LEN_W-1:0]  len = '0;
    logic              s_valid = 1'b0;
    logic [7:0]        s_data = '0;
    logic              s_ready;
    logic [18:0]       bus_addr;
    logic [7:0]        bus_dout;
    logic [7:0]        bus_din;
    logic              bus_oe, mreq_n, rd_n, wr_n, busy, done;
    logic [7:0]        rdata;

    int errors = 0;
    int checks = 0;

    logic [7:0] mem [logic [18:0]];

    // bus-side monitor state
    logic        prev_wr = 1'b1, prev_rd = 1'b1, prev_mreq = 1'b1;
    int          wr_len = 0, rd_len = 0;
    int          wr_pulses = 0, rd_pulses = 0, mreq_falls = 0;
    int          oe_in_read = 0, ready_cycles = 0, busy_gaps = 0;
    logic [18:0] last_waddr;
    logic [7:0]  last_wdat;

    // block source
    logic [7:0]  src [0:63];
    int          src_len = 0, src_idx = 0;
    logic        hs;
    int          cyc = 0;

    always #5 clk = ~clk;

    memcyc_engine #(.WR_W(WR_W), .RD_W(RD_W), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst(rst), .start(start), .cmd(cmd), .addr(addr),
        .wdata(wdata), .len(len), .s_valid(s_valid), .s_data(s_data),
        .s_ready(s_ready), .bus_addr(bus_addr), .bus_dout(bus_dout),
        .bus_din(bus_din), .bus_oe(bus_oe), .mreq_n(mreq_n), .rd_n(rd_n),
        .wr_n(wr_n), .busy(busy), .done(done), .rdata(rdata)
    );

    function automatic logic [7:0] pattern(logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] model_byte(logic [18:0] a);
        if (mem.exists(a)) return mem[a];
        return pattern(a);
    endfunction

    assign bus_din = !rd_n ? model_byte(bus_addr) : 8'hEE;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (!wr_n) begin
                wr_len++;
                last_waddr = bus_addr;
                last_wdat  = bus_dout;
            end else if (!prev_wr) begin
                mem[last_waddr] = last_wdat;
                wr_pulses++;
                check(wr_len == WR_W, "R2 write strobe width", wr_len, WR_W);
                wr_len = 0;
            end
            if (!rd_n) begin
                rd_len++;
                if (bus_oe) oe_in_read++;
            end else if (!prev_rd) begin
                rd_pulses++;
                check(rd_len == RD_W, "R4 read strobe width", rd_len, RD_W);
                rd_len = 0;
            end
            if (!mreq_n && prev_mreq) mreq_falls++;
            if (s_ready) ready_cycles++;
            prev_wr   = wr_n;
            prev_rd   = rd_n;
            prev_mreq = mreq_n;
        end
    end

    // block stream driver with random stalls
    initial begin
        forever begin
            @(negedge clk);
            hs = s_valid & s_ready;
            @(posedge clk);
            #1;
            if (hs) src_idx++;
            if (src_idx < src_len) begin
                s_valid = ($urandom % 4) != 0;
                s_data  = src[src_idx];
            end else begin
                s_valid = 1'b0;
            end
        end
    end

    task automatic issue(input logic [1:0] c, input logic [18:0] a,
                         input logic [7:0] d, input int l);
        @(posedge clk);
        #1;
        start = 1'b1;
        cmd   = c;
        addr  = a;
        wdata = d;
        len   = LEN_W'(l);
        @(posedge clk);
        #1;
        start = 1'b0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        busy_gaps = 0;
        forever begin
            @(negedge clk);
            n++;
            if (!busy) busy_gaps++;
            if (done) break;
            if (n > 2000) begin
                check(1'b0, "R11 done never seen", n, 0);
                break;
            end
        end
        @(negedge clk);
        check(!done, "R11 done single pulse", done, 0);
    endtask

    task automatic clear_counts();
        wr_pulses = 0; rd_pulses = 0; mreq_falls = 0;
        oe_in_read = 0; ready_cycles = 0;
    endtask

    task automatic do_op(input logic [1:0] c, input logic [18:0] a,
                         input logic [7:0] d, input int l);
        int n;
        int bursty;
        int exp_p;
        logic [7:0] exp_rd;
        bursty = (c >= 2) ? 1 : 0;
        exp_p  = bursty ? l : 1;
        exp_rd = model_byte(a);
        if (c == 2'd3) begin
            for (int i = 0; i < l; i++) src[i] = 8'($urandom);
            src_idx = 0;
            src_len = l;
        end
        clear_counts();
        issue(c, a, d, l);
        wait_done(n);
        check(busy_gaps == 0, "R11 busy held until done", busy_gaps, 0);
        if (c == 2'd0) begin
            check(rd_pulses == 1 && wr_pulses == 0, "R4 one read pulse", rd_pulses, 1);
            check(rdata == exp_rd, "R4 read data", rdata, exp_rd);
            check(oe_in_read == 0, "R5 oe during read", oe_in_read, 0);
            check(n == RD_W + 3, "R11 read cycles", n, RD_W + 3);
        end else begin
            check(wr_pulses == exp_p && rd_pulses == 0,
                  bursty ? "R6 burst pulse count" : "R2 one write pulse", wr_pulses, exp_p);
        end
        if (c == 2'd1) begin
            check(model_byte(a) == d, "R2 write data", model_byte(a), d);
            check(n == WR_W + 3, "R11 write cycles", n, WR_W + 3);
        end
        if (c == 2'd2) begin
            for (int i = 0; i < l; i++) begin
                logic [18:0] ai;
                ai = a + 19'(i);
                check(model_byte(ai) == d, "R9 R6 fill byte", model_byte(ai), d);
            end
            check(n == l * (WR_W + 1) + 2 || l == 0, "R11 fill cycles", n, l * (WR_W + 1) + 2);
        end
        if (c == 2'd3) begin
            for (int i = 0; i < l; i++) begin
                logic [18:0] ai;
                ai = a + 19'(i);
                check(model_byte(ai) == src[i], "R7 block byte", model_byte(ai), src[i]);
            end
        end else begin
            check(ready_cycles == 0, "R7 ready outside block", ready_cycles, 0);
        end
        if (bursty && l == 0) begin
            check(n == 1, "R8 zero length done latency", n, 1);
            check(mreq_falls == 0 && wr_pulses == 0, "R8 zero length quiet", mreq_falls, 0);
        end else begin
            check(mreq_falls == 1, "R6 R3 single mreq period", mreq_falls, 1);
        end
        src_len = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) cyc++;

    initial begin
        int n;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(mreq_n && rd_n && wr_n, "R1 strobes idle high",
              {mreq_n, rd_n, wr_n}, 3'b111);
        check(!bus_oe && !busy && !done && !s_ready, "R1 outputs low",
              {bus_oe, busy, done, s_ready}, 0);

        // directed single cycles
        do_op(2'd1, 19'h0_1234, 8'hA7, 9);          // R2, len ignored
        do_op(2'd0, 19'h0_1234, 8'h00, 0);          // R4 reads back
        do_op(2'd0, 19'h5_0F0F, 8'h00, 3);          // R4 default pattern
        // fills across bank boundary and top wrap
        do_op(2'd2, 19'h0_FFFE, 8'h3C, 4);          // R9 bank crossing
        do_op(2'd2, 19'h7_FFFE, 8'h81, 4);          // R9 wrap to zero
        check(model_byte(19'h0_0001) == 8'h81, "R9 wrapped address", model_byte(19'h0_0001), 8'h81);
        // zero lengths
        do_op(2'd2, 19'h0_2000, 8'h11, 0);          // R8
        do_op(2'd3, 19'h0_2000, 8'h11, 0);          // R8
        // block copy with stalls
        do_op(2'd3, 19'h2_0100, 8'h00, 12);         // R7

        // R10: start pulsed mid-burst must be ignored
        clear_counts();
        issue(2'd2, 19'h0_1000, 8'hC3, 6);
        @(posedge clk);
        #1;
        start = 1'b1; cmd = 2'd1; addr = 19'h0_2222; wdata = 8'hA5; len = 1;
        @(posedge clk);
        #1 start = 1'b0;
        wait_done(n);
        check(wr_pulses == 6, "R10 pulses unchanged by start", wr_pulses, 6);
        do_op(2'd0, 19'h0_2222, 8'h00, 0);
        check(rdata == pattern(19'h0_2222), "R10 ignored write absent", rdata, pattern(19'h0_2222));

        // random mix
        for (int k = 0; k < 60; k++) begin
            logic [1:0]  c;
            logic [18:0] a;
            c = 2'($urandom);
            a = 19'($urandom);
            if (($urandom % 5) == 0) a = 19'h7_FFFC + 19'($urandom % 4);
            if (($urandom % 5) == 0) a = {3'($urandom), 16'hFFFD};
            do_op(c, a, 8'($urandom), int'($urandom % 7));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule